// File: doc/BRIEF.md
# SPI Mode-0 Register Access Slave

This block lets an external host reach a small parallel register file over a four-pin serial link: an active-low select, a serial clock, a serial data input and a serial data output with a separate output enable. Serial traffic uses mode 0. The clock idles low, input bits are taken on its rising edge and output bits change on its falling edge. Bytes are eight bits long and travel most-significant bit first. All three input pins are synchronised into a system clock that must run at least four times the serial clock rate. A 20 MHz serial clock therefore needs a system clock of 80 MHz or more.

Each select-low period is one transaction. Its first byte is a command. The top bit selects read (1) or write (0) and the low seven bits give a starting register address. In a write transaction, every further complete byte becomes a one-cycle write strobe, and the address then steps forward by one. In a read transaction, the addressed register is fetched as soon as the command byte completes and is shifted out during the next byte. A new fetch, at the next address, follows every completed read byte. The link is half duplex. The output is enabled only while a read-data byte is being shifted out, and the input pin is ignored during those bytes. A byte cut short by the select rising is dropped with no side effect.

Top module: `spi_reg_slave`

## Requirements
- R1: Bits are taken on rising serial-clock edges while select is low, most-significant bit first, eight to a byte.
- R2: The first byte of a transaction is a command: bit 7 = 1 opens a read, bit 7 = 0 opens a write, and bits 6:0 give the start address.
- R3: In a write, every complete data byte yields exactly one `reg_we_o` pulse of one system cycle, with that byte on `reg_wdata_o` and the current address on `reg_addr_o`.
- R4: Within a write burst, the address rises by one after each strobe and wraps from 0x7F to 0x00.
- R5: In a read, a one-cycle `reg_re_o` pulse at the command address follows the command byte. The fetched value's MSB is on `so_o` after the next falling clock edge, and later bits follow on the falling edges that come after it.
- R6: In a read burst, every complete read-data byte is followed by one `reg_re_o` pulse at the next address (wrapping from 0x7F to 0x00). `reg_re_o` and `reg_we_o` are never high together.
- R7: `so_oe_o` is high only from the falling edge that opens a read-data byte up to that byte's eighth rising edge. It is low between bytes, during command and write bytes, and whenever select is high.
- R8: Activity on `si_i` during read-data bytes changes neither the read data nor any register access.
- R9: When select rises, the bit count and command state are cleared. A partial byte is discarded and causes no write and no fetch.
- R10: Serial-clock edges while select is high have no effect.
- R11: After reset, `so_oe_o`, `reg_we_o` and `reg_re_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from host, idles low |
| cs_ni | input | 1 | Select from host, active low |
| si_i | input | 1 | Serial data from host |
| so_o | output | 1 | Serial data to host, valid while `so_oe_o` is high |
| so_oe_o | output | 1 | Output enable for the tri-state pad driving `so_o` |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_re_o | output | 1 | Register read strobe, one cycle; `reg_rdata_i` is taken in the same cycle |
| reg_addr_o | output | 7 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid in the cycle `reg_re_o` is high |

## Verification
The bound checker enforces these properties on every cycle. The output enable must drop once select is high and may be set only in a read transaction. The input shifter must hold still throughout read phases. Both strobes must be single-cycle and never overlap, and every write strobe must come directly after a completed byte. The bench's scenarios cover the rest: bit order, address stepping and wrap, the exact window of the output enable, the data driven on `so_o`, and the absence of side effects after a partial byte or after clock edges while select is high.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr <= {STAGES{RST_VAL[b]}};
      else         sr <= {sr[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sr[STAGES-1];
  end
endmodule

// File: rtl/spi_slv_rx.sv
module spi_slv_rx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sck_rise_i,
  input  logic              si_i,
  input  logic              hold_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [DATA_W-1:0] sh_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!cs_act_i) begin
      cnt_q <= '0;
    end else if (sck_rise_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      // read-data bytes keep framing but never touch the shifter
      if (!hold_i) sh_q <= {sh_q[DATA_W-2:0], si_i};
    end
  end

  assign bit_cnt_o   = cnt_q;
  assign byte_done_o = cs_act_i & sck_rise_i & (cnt_q == LAST);
  assign byte_o      = {sh_q[DATA_W-2:0], si_i};
  assign sh_o        = sh_q;
endmodule

// File: rtl/spi_slv_tx.sv
module spi_slv_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              sck_fall_i,
  input  logic              first_bit_i,
  input  logic              byte_end_i,
  output logic              so_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] sh_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q <= load_data_i;
    end else if (active_i && sck_fall_i && !first_bit_i) begin
      sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       oe_q <= 1'b0;
    else if (!active_i || byte_end_i)  oe_q <= 1'b0;
    else if (sck_fall_i && first_bit_i) oe_q <= 1'b1;
  end

  assign so_o = oe_q & sh_q[DATA_W-1];
  assign oe_o = oe_q;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W = DATA_W - 1,
  localparam int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [2:0] pins_s;
  logic       sck_s, cs_n_s, si_s, sck_q;
  logic       cs_act, sck_rise, sck_fall;

  spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({si_i, cs_ni, sck_i}),
    .q_o   (pins_s)
  );
  assign {si_s, cs_n_s, sck_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end

  assign cs_act   = ~cs_n_s;
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_pend_q, we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_done;
  logic [DATA_W-1:0] rx_byte, rx_sh;

  spi_slv_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sck_rise_i (sck_rise),
    .si_i       (si_s),
    .hold_i     (phase_q == PH_RD),
    .bit_cnt_o  (bit_cnt),
    .byte_done_o(byte_done),
    .byte_o     (rx_byte),
    .sh_o       (rx_sh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_CMD;
      addr_q    <= '0;
      rd_pend_q <= 1'b0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
    end else begin
      we_q      <= 1'b0;
      rd_pend_q <= 1'b0;
      if (we_q) addr_q <= addr_q + 1'b1;
      if (!cs_act) begin
        phase_q <= PH_CMD;
      end else if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            addr_q <= rx_byte[ADDR_W-1:0];
            if (rx_byte[DATA_W-1]) begin
              phase_q   <= PH_RD;
              rd_pend_q <= 1'b1;
            end else begin
              phase_q <= PH_WR;
            end
          end
          PH_WR: begin
            we_q    <= 1'b1;
            wdata_q <= rx_byte;
          end
          PH_RD: begin
            addr_q    <= addr_q + 1'b1;
            rd_pend_q <= 1'b1;
          end
          default: phase_q <= PH_CMD;
        endcase
      end
    end
  end

  spi_slv_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (cs_act && phase_q == PH_RD),
    .load_i     (rd_pend_q),
    .load_data_i(reg_rdata_i),
    .sck_fall_i (sck_fall),
    .first_bit_i(bit_cnt == '0),
    .byte_end_i (byte_done && phase_q == PH_RD),
    .so_o       (so_o),
    .oe_o       (so_oe_o)
  );

  assign reg_we_o    = we_q;
  assign reg_re_o    = rd_pend_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act_i,
  input phase_e            phase_i,
  input logic              byte_done_i,
  input logic [DATA_W-1:0] rx_sh_i,
  input logic              so_oe_o,
  input logic              reg_we_o,
  input logic              reg_re_o
);
  assert_oe_off_deselect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !so_oe_o);

  assert_oe_read_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (phase_i == PH_RD));

  assert_si_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_RD) |=> $stable(rx_sh_i));

  assert_we_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_we_full_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(byte_done_i));

  assert_re_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  assert_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  assert_re_in_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> (phase_i == PH_RD));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_act_i   (cs_act),
  .phase_i    (phase_q),
  .byte_done_i(byte_done),
  .rx_sh_i    (rx_sh),
  .so_oe_o    (so_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o)
);

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb;
  localparam int HALF = 25;

  logic clk = 1'b0;
  logic rst_n;
  logic sck, cs_n, si;
  logic so, so_oe, we, re;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;

  logic [7:0]  mem     [128];
  logic [7:0]  exp_mem [128];
  logic [14:0] wq[$];
  logic [6:0]  rq[$];
  int checks = 0, fails = 0, we_cnt = 0, re_cnt = 0, idle_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .reg_we_o(we), .reg_re_o(re),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  assign rdata = mem[addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp_v, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp_v, $time);
    end
  endtask

  // register-file model and per-clock comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 5);
    end else if (!done) begin
      chk(!(we && re), "R6", {30'd0, we, re}, 0, "strobe overlap");
      if (we) begin
        we_cnt++;
        if (wq.size() == 0) chk(1'b0, "R3 R9", {24'd0, addr, 1'b0}, 0, "unexpected write");
        else begin
          logic [14:0] e;
          e = wq.pop_front();
          chk({addr, wdata} == e, "R1 R3 R4", {addr, wdata}, e, "write addr/data");
        end
        mem[addr] = wdata;
      end
      if (re) begin
        re_cnt++;
        if (rq.size() == 0) chk(1'b0, "R5 R9", addr, 0, "unexpected fetch");
        else begin
          logic [6:0] ea;
          ea = rq.pop_front();
          chk(addr == ea, "R5 R6", addr, ea, "fetch addr");
        end
      end
      idle_cnt = cs_n ? idle_cnt + 1 : 0;
      if (idle_cnt > 4) chk(!so_oe, "R7", so_oe, 0, "oe while deselected");
    end
  end

  task automatic xfer(input logic [7:0] tx, input bit rd, input logic [7:0] exp_b);
    for (int i = 7; i >= 0; i--) begin
      si = rd ? 1'($urandom) : tx[i];
      #(HALF);
      if (rd) begin
        chk(so_oe === 1'b1, "R7", so_oe, 1, "oe in read byte");
        chk(so === exp_b[i], "R5 R8", so, exp_b[i], "read bit");
      end else begin
        chk(so_oe === 1'b0, "R7", so_oe, 0, "oe in cmd/write byte");
      end
      sck = 1'b1;
      if (rd) begin
        #10 si = ~si;  // R8: input toggles while output is driven
        #10 if (i == 0) chk(so_oe === 1'b0, "R7", so_oe, 0, "oe after 8th rise");
        #5;
      end else #(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic wr_txn(input logic [6:0] a0, input int n, input logic [7:0] seed);
    logic [6:0] a;
    a = a0;
    cs_n = 1'b0; #(HALF);
    xfer({1'b0, a0}, 1'b0, 8'h0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = seed + 8'(k * 37);
      wq.push_back({a, d});
      exp_mem[a] = d;
      xfer(d, 1'b0, 8'h0);
      a = a + 7'd1;
    end
    #(HALF); cs_n = 1'b1; #100;
  endtask

  task automatic rd_txn(input logic [6:0] a0, input int n);
    logic [6:0] a;
    a = a0;
    cs_n = 1'b0; #(HALF);
    rq.push_back(a);
    xfer({1'b1, a0}, 1'b0, 8'h0);
    for (int k = 0; k < n; k++) begin
      rq.push_back(a + 7'd1);
      xfer(8'h0, 1'b1, exp_mem[a]);
      a = a + 7'd1;
    end
    #(HALF); cs_n = 1'b1; #100;
  endtask

  task automatic partial_bits(input int nb);
    for (int i = 0; i < nb; i++) begin
      si = 1'b1; #(HALF); sck = 1'b1; #(HALF); sck = 1'b0;
    end
  endtask

  initial begin
    #900us;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i * 3 + 5);
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    repeat (5) @(negedge clk);
    chk(so_oe == 1'b0 && we == 1'b0 && re == 1'b0, "R11", {so_oe, we, re}, 0, "reset outputs");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(so_oe == 1'b0 && we == 1'b0 && re == 1'b0, "R11", {so_oe, we, re}, 0, "after reset");

    // R1 R2 R3: single write, then burst with wrap R4
    wr_txn(7'h12, 1, 8'hA5);
    wr_txn(7'h7E, 3, 8'h3C);
    chk(mem[7'h7F] == exp_mem[7'h7F] && mem[0] == exp_mem[0], "R4", mem[0], exp_mem[0], "wrap write");

    // R2 R5: single read of written data, burst read with wrap R6
    rd_txn(7'h12, 1);
    rd_txn(7'h7E, 3);
    rd_txn(7'h40, 4);

    // R9: partial byte as command, then partial after write command
    w0 = we_cnt; r0 = re_cnt;
    cs_n = 1'b0; #(HALF); partial_bits(3); #(HALF); cs_n = 1'b1; #100;
    cs_n = 1'b0; #(HALF); xfer({1'b0, 7'h10}, 1'b0, 8'h0); partial_bits(3);
    #(HALF); cs_n = 1'b1; #100;
    chk(we_cnt == w0 && re_cnt == r0, "R9", we_cnt - w0, 0, "side effect of partial byte");
    chk(mem[7'h10] == exp_mem[7'h10], "R9", mem[7'h10], exp_mem[7'h10], "reg after partial");

    // R10: clock edges with select high
    for (int i = 0; i < 12; i++) begin
      si = 1'(i); #(HALF); sck = 1'b1; #(HALF); sck = 1'b0;
    end
    #100;
    chk(we_cnt == w0 && re_cnt == r0, "R10", we_cnt - w0, 0, "clock while deselected");
    chk(so_oe == 1'b0, "R10", so_oe, 0, "oe while deselected");

    // framing is clean afterwards
    wr_txn(7'h10, 2, 8'h81);
    rd_txn(7'h10, 2);

    #200;
    chk(wq.size() == 0, "R3", wq.size(), 0, "pending writes");
    chk(rq.size() == 0, "R6", rq.size(), 0, "pending fetches");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule